// File: doc/BRIEF.md
# FIFO Read Width Adapter

This block holds 36-bit entries in a single-clock FIFO and delivers them through an 18-bit read port. Each stored entry is treated as four 9-bit fields. Field F3 is bits 35..27, F2 is bits 26..18, F1 is bits 17..9 and F0 is bits 8..0. In split mode each entry leaves the port as two 18-bit halves. The upper half is {F3,F2}, which is entry bits 35..18. The lower half is {F1,F0}, which is entry bits 17..0. The storage slot is released only once both halves have gone out. In direct mode each read returns the lower half and releases the entry at once.

Three settings are captured while `rst` is high and are ignored after that:
- the half order (`cfg_big_end`);
- the presentation style (`cfg_fwft`);
- split or direct mode (`cfg_word_mode`).

In standard presentation, a read request loads the output register and `rd_flag` means "empty". In first-word-fall-through presentation, the first half is loaded without any request and `rd_flag` means "ready". A read request is `rd_cs_n` low together with `rd_en` high at a rising clock edge. While `rd_cs_n` is high, the data pins are released to high impedance, and `rd_oe` reports that state.

Top module: `fifo_rd_width_adapter`

## Requirements
- R1: After synchronous reset, the FIFO is empty and `wr_full`=0. The output register reads 0. `rd_flag` is 1 in standard presentation and 0 in first-word-fall-through presentation. The half pointer points at the first half.
- R2: With `cfg_big_end`=1 captured in reset and `cfg_word_mode`=1, the first read of an entry returns bits 35..18 and the second read returns bits 17..0.
- R3: With `cfg_big_end`=0 captured in reset and `cfg_word_mode`=1, the first read of an entry returns bits 17..0 and the second read returns bits 35..18.
- R4: `cfg_big_end`, `cfg_fwft` and `cfg_word_mode` are sampled only while `rst`=1. Changing them afterwards has no effect on order, flag meaning or mode.
- R5: A read happens only at a rising edge where `rd_cs_n`=0 and `rd_en`=1. In standard presentation, the output register holds its value in every other cycle.
- R6: In split mode, an entry is retired only after its second half has been read. In standard presentation, `rd_flag` (empty) stays 0 between the two halves and rises after the second half of the last entry is read.
- R7: In standard presentation, read requests while `rd_flag`=1 are ignored. The data is held and the half pointer is unchanged, so the next read after a write returns the first half.
- R8: In first-word-fall-through presentation, the first half of a newly available entry is loaded one cycle after the FIFO becomes non-empty, with no request, and `rd_flag` (ready) becomes 1. A read advances to the next half or entry. `rd_flag` falls when a read consumes the last available half.
- R9: `rd_oe` equals the inverse of `rd_cs_n`. `rd_data` is high impedance while `rd_cs_n`=1.
- R10: With `cfg_word_mode`=0 captured in reset, every read returns bits 17..0 of the head entry and retires that entry.
- R11: `wr_full` is 1 when DEPTH entries are stored. Writes while full are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration inputs |
| cfg_big_end | input | 1 | 1: upper half first; 0: lower half first |
| cfg_fwft | input | 1 | 1: first-word-fall-through presentation; 0: standard |
| cfg_word_mode | input | 1 | 1: split each entry into two reads; 0: direct, low half only |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Entry to store |
| wr_full | output | 1 | FIFO holds DEPTH entries |
| rd_cs_n | input | 1 | Active-low port select |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Read data; high impedance while deselected |
| rd_oe | output | 1 | Data pins driven |
| rd_flag | output | 1 | Empty (standard) or ready (first-word-fall-through) |

## Verification
A half pointer that is stuck or skips shows up at the port within two reads. Both halves of an entry come out identical, or they come out in swapped order, compared with what the bench model expects. A retirement that comes one half too early or too late makes every later word misaligned. It also moves the empty or ready flag edge by one read, and the bench sees that in the very next sampled cycle. A configuration latch that follows its inputs after reset shows up on the first read after the bench flips those inputs.

// File: rtl/wa_pkg.sv
package wa_pkg;

    localparam int FIELD_W = 9;
    localparam int ENTRY_W = 4 * FIELD_W;
    localparam int PORT_W  = 2 * FIELD_W;

    typedef enum logic {
        ORD_LITTLE = 1'b0,
        ORD_BIG    = 1'b1
    } order_e;

    typedef enum logic {
        PRES_STD  = 1'b0,
        PRES_FWFT = 1'b1
    } pres_e;

    typedef struct packed {
        order_e order;
        pres_e  pres;
        logic   split;
    } cfg_t;

    // f3 occupies the most significant field
    typedef struct packed {
        logic [FIELD_W-1:0] f3;
        logic [FIELD_W-1:0] f2;
        logic [FIELD_W-1:0] f1;
        logic [FIELD_W-1:0] f0;
    } entry_t;

    function automatic logic [PORT_W-1:0] pick_half(entry_t e, order_e o,
                                                    logic second, logic split);
        logic upper;
        if (!split) return {e.f1, e.f0};
        upper = (o == ORD_BIG) ? !second : second;
        return upper ? {e.f3, e.f2} : {e.f1, e.f0};
    endfunction

endpackage

// File: rtl/wa_mode_latch.sv
module wa_mode_latch
    import wa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);
    // configuration follows its inputs only while reset is held
    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/wa_store.sv
module wa_store
    import wa_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  entry_t                       push_data,
    input  logic                         pop,
    output entry_t                       head,
    output logic                         avail,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    entry_t            mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic              push_ok;

    function automatic logic [ADDR_W-1:0] bump(logic [ADDR_W-1:0] p);
        return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign avail   = (count != '0);
    assign push_ok = push && !full;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop)     rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wa_read_ctrl.sv
module wa_read_ctrl
    import wa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              rd_req,
    input  logic              avail,
    input  entry_t            head,
    output logic              pop,
    output logic              half_q,
    output logic [PORT_W-1:0] data_q,
    output logic              flag
);
    logic valid_q;
    logic last;
    logic fetch;
    logic drain;

    always_comb begin
        last = !cfg.split || half_q;
        if (cfg.pres == PRES_STD) begin
            fetch = rd_req && avail;
            drain = 1'b0;
            flag  = !avail;
        end else begin
            fetch = avail && (!valid_q || rd_req);
            drain = rd_req && valid_q && !avail;
            flag  = valid_q;
        end
        pop = fetch && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= 1'b0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (fetch) begin
            data_q  <= pick_half(head, cfg.order, half_q, cfg.split);
            valid_q <= 1'b1;
            half_q  <= last ? 1'b0 : 1'b1;
        end else if (drain) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fifo_rd_width_adapter.sv
module fifo_rd_width_adapter
    import wa_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_big_end,
    input  logic        cfg_fwft,
    input  logic        cfg_word_mode,
    input  logic        wr_en,
    input  logic [35:0] wr_data,
    output logic        wr_full,
    input  logic        rd_cs_n,
    input  logic        rd_en,
    output logic [17:0] rd_data,
    output logic        rd_oe,
    output logic        rd_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    cfg_t              cfg_in;
    cfg_t              cfg_q;
    entry_t            head;
    logic              avail;
    logic              pop;
    logic              half_q;
    logic [PORT_W-1:0] data_q;
    logic [CNT_W-1:0]  count;

    assign cfg_in = '{order: order_e'(cfg_big_end),
                      pres:  pres_e'(cfg_fwft),
                      split: cfg_word_mode};

    wa_mode_latch u_mode (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    wa_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (entry_t'(wr_data)),
        .pop       (pop),
        .head      (head),
        .avail     (avail),
        .full      (wr_full),
        .count     (count)
    );

    wa_read_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg_q),
        .rd_req (!rd_cs_n && rd_en),
        .avail  (avail),
        .head   (head),
        .pop    (pop),
        .half_q (half_q),
        .data_q (data_q),
        .flag   (rd_flag)
    );

    assign rd_oe   = !rd_cs_n;
    assign rd_data = rd_oe ? data_q : 'z;
endmodule

// File: rtl/wa_checker.sv
module wa_checker
    import wa_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rd_cs_n,
    input logic                       rd_en,
    input logic                       rd_flag,
    input logic                       wr_en,
    input logic                       wr_full,
    input cfg_t                       cfg_q,
    input logic                       half_q,
    input logic [PORT_W-1:0]          data_q,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    assert_half_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (half_q == 1'b0));

    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_q));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.pres == PRES_STD && !(!rd_cs_n && rd_en)) |=> $stable(data_q));

    assert_pop_second_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.split && pop) |-> half_q);

    assert_empty_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.pres == PRES_STD && rd_flag) |=> ($stable(half_q) && $stable(data_q)));

    assert_fwft_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.pres == PRES_FWFT && !rd_flag && count != '0) |=> rd_flag);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_full && wr_en && !pop) |=> $stable(count));

    always @(posedge clk) begin
        if (!rst) begin
            assert_count_bound_R11: assert (count <= CNT_W'(DEPTH));
        end
    end
endmodule

bind fifo_rd_width_adapter wa_checker #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_cs_n (rd_cs_n),
    .rd_en   (rd_en),
    .rd_flag (rd_flag),
    .wr_en   (wr_en),
    .wr_full (wr_full),
    .cfg_q   (cfg_q),
    .half_q  (half_q),
    .data_q  (data_q),
    .pop     (pop),
    .count   (count)
);

// File: tb/tb_fifo_rd_width_adapter.sv
`timescale 1ns/1ps
module tb_fifo_rd_width_adapter;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_big_end = 1'b0, cfg_fwft = 1'b0, cfg_word_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_cs_n = 1'b1, rd_en = 1'b0;
    wire         wr_full;
    wire  [17:0] rd_data;
    wire         rd_oe;
    wire         rd_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    logic [35:0] q[$];
    logic        m_half, m_valid, m_be, m_fwft, m_split;
    logic [17:0] m_data;

    fifo_rd_width_adapter #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .cfg_big_end(cfg_big_end), .cfg_fwft(cfg_fwft), .cfg_word_mode(cfg_word_mode),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_oe(rd_oe), .rd_flag(rd_flag)
    );

    always #10 clk = ~clk;

    function automatic logic [17:0] exp_half(logic [35:0] e, logic be, logic second, logic split);
        if (!split) return e[17:0];
        if (be) return second ? e[17:0] : e[35:18];
        return second ? e[35:18] : e[17:0];
    endfunction

    task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic be, input logic fw, input logic sp);
        @(negedge clk);
        cfg_big_end = be; cfg_fwft = fw; cfg_word_mode = sp;
        rst = 1'b1; wr_en = 1'b0; rd_cs_n = 1'b0; rd_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        m_half = 1'b0; m_valid = 1'b0; m_data = '0;
        m_be = be; m_fwft = fw; m_split = sp;
        chk({35'd0, rd_flag}, {35'd0, !fw}, "R1 flag");
        chk({35'd0, wr_full}, 36'd0, "R1 full");
        chk({18'd0, rd_data}, 36'd0, "R1 data");
    endtask

    task automatic cycle(input logic we, input logic [35:0] wd, input logic csn, input logic re);
        logic avail, full, req, last, fetch, drain;
        string tag;
        wr_en = we; wr_data = wd; rd_cs_n = csn; rd_en = re;
        @(posedge clk);
        avail = (q.size() != 0);
        full  = (q.size() == DEPTH);
        req   = !csn && re;
        last  = !m_split || m_half;
        if (!m_fwft) begin
            fetch = req && avail; drain = 1'b0;
        end else begin
            fetch = avail && (!m_valid || req); drain = req && m_valid && !avail;
        end
        if (fetch) begin
            m_data = exp_half(q[0], m_be, m_half, m_split);
            m_valid = 1'b1;
            if (last) begin
                void'(q.pop_front());
                m_half = 1'b0;
            end else m_half = 1'b1;
        end else if (drain) m_valid = 1'b0;
        if (we && !full) q.push_back(wd);
        @(negedge clk);
        chk({35'd0, rd_oe}, {35'd0, !csn}, "R9 oe");
        if (!csn) begin
            tag = m_split ? (m_be ? "R2 R4 R5 data" : "R3 R4 R5 data") : "R10 R4 R5 data";
            if (m_fwft) tag = {tag, " R8"};
            chk({18'd0, rd_data}, {18'd0, m_data}, tag);
        end
        chk({35'd0, rd_flag}, {35'd0, m_fwft ? m_valid : (q.size() == 0)},
            m_fwft ? "R8 ready" : "R6 R7 empty");
        chk({35'd0, wr_full}, {35'd0, q.size() == DEPTH}, "R11 full");
    endtask

    initial begin
        logic [63:0] r;
        void'($urandom(32'd4242));
        for (int c = 0; c < 8; c++) begin
            do_reset(c[0], c[1], c[2]);
            // R7: reads on an empty FIFO are ignored
            for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b0, 1'b1);
            cycle(1'b1, 36'h123456789, 1'b0, 1'b0);
            cycle(1'b1, 36'hFEDCBA987, 1'b0, 1'b0);
            for (int i = 0; i < 4; i++) cycle(1'b0, '0, 1'b0, 1'b1);
            // random traffic with configuration inputs toggling (R4)
            for (int i = 0; i < 300; i++) begin
                r = {$urandom, $urandom};
                cfg_big_end = r[40]; cfg_fwft = r[41]; cfg_word_mode = r[42];
                cycle(r[43], r[35:0], ($urandom % 4) == 0, r[44]);
            end
            // R11: overfill, then drain everything
            for (int i = 0; i < DEPTH + 3; i++) begin
                r = {$urandom, $urandom};
                cycle(1'b1, r[35:0], 1'b1, 1'b1);
            end
            for (int i = 0; i < 2 * DEPTH + 4; i++) cycle(1'b0, '0, 1'b0, 1'b1);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule